// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block listens passively to the clock and data lines of a two-wire serial bus and recognises bus start and stop framing conditions. Both lines are brought into the system clock domain through a two-stage synchronizer and then cleaned by a glitch filter, so a level change only counts once it has stayed put for a programmable number of clocks. A falling data edge while the clock line is high marks a start; a rising data edge while the clock line is high marks a stop. The block keeps a busy flag that is set from a start until a stop.

Each condition sets a sticky raw status bit. Software acknowledges a bit by pulsing a 1 on the matching bit of the clear port. A mask register selects which raw bits are passed to the masked status. A global enable then decides whether any masked bit raises the single interrupt line. The block drives nothing on the bus. A slave controller or an arbiter can use it to learn when the bus is owned and when it is free. All pins are plain control and status pins. No data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `bus_cond_monitor`

## Requirements
- R1: A filtered data-line fall, with the filtered clock line high on the sample before the edge and on the sample at the edge, sets raw status bit 0 (start).
- R2: A filtered data-line rise under the same clock-line rule sets raw status bit 1 (stop).
- R3: `bus_busy` goes to 1 on a start and to 0 on a stop. A data-line change while the clock line is low sets no status bit and leaves `bus_busy` unchanged.
- R4: A start while `bus_busy` is already 1 (a repeated start) still sets raw bit 0, and `bus_busy` stays 1.
- R5: `masked_stat` equals `raw_stat` AND the mask register. The mask register loads `mask_wdata` on a clock where `mask_wr` is 1. `irq` is 1 exactly when `irq_en` is 1 and `masked_stat` is nonzero.
- R6: A raw bit stays 1 until a clock where the same bit of `clr_w1c` is 1. Clear bits written as 0 have no effect.
- R7: When a clear and a new event hit the same raw bit on the same clock, the bit ends up 1.
- R8: A filtered line takes a new level only after the synchronized input has held that level for `filt_cycles` consecutive clocks. A value of 0 acts as 1. Shorter pulses are dropped.
- R9: After reset, `bus_busy` is 0, both raw bits are 0 and both mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Bus data line, asynchronous |
| scl_in | input | 1 | Bus clock line, asynchronous |
| filt_cycles | input | CNT_W | Stable clocks required to accept a level change |
| irq_en | input | 1 | Global interrupt enable |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_wdata | input | 2 | New mask: bit 0 start, bit 1 stop |
| clr_w1c | input | 2 | Write-one-to-clear strobes: bit 0 start, bit 1 stop |
| raw_stat | output | 2 | Sticky raw status: bit 0 start, bit 1 stop |
| masked_stat | output | 2 | Raw status AND mask |
| bus_busy | output | 1 | Bus owned, between start and stop |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear and a fresh event landing on the same raw bit in the same clock. The pipeline is two synchronizer stages plus the filter, and the event is then registered one clock later. The bench counts these edges from a known drive point on the data line and raises the clear strobe for exactly the clock in which the detected event reaches the status register. The bit is already set by an earlier start, so a design where the clear wins would show a 0. The glitch filter is driven with pulses one clock shorter than the programmed length. With a length of 0, a single-clock pulse is expected to pass.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  localparam int NUM_EV   = 2;
  localparam int EV_START = 0;
  localparam int EV_STOP  = 1;
  localparam int NUM_LINES = 2;
  localparam int LN_SDA   = 0;
  localparam int LN_SCL   = 1;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic [CNT_W-1:0] filt_cycles,
  output logic             line_out
);
  logic             meta_q, sync_q, filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thresh;

  // a length of zero behaves like one
  always_comb begin
    if (filt_cycles == '0) thresh = '0;
    else                   thresh = filt_cycles - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
      if (sync_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q >= thresh) begin
        filt_q <= sync_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_out = filt_q;
endmodule

// File: rtl/cond_detect.sv
module cond_detect
  import bcm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sda_f,
  input  logic    scl_f,
  output ev_vec_t events,
  output logic    busy
);
  logic sda_q, scl_q, scl_held;
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_f;
      scl_q <= scl_f;
    end
  end

  assign scl_held = scl_q & scl_f;

  always_comb begin
    events           = '0;
    events[EV_START] = scl_held & sda_q & ~sda_f;
    events[EV_STOP]  = scl_held & ~sda_q & sda_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_q <= 1'b0;
    else if (events[EV_START]) busy_q <= 1'b1;
    else if (events[EV_STOP])  busy_q <= 1'b0;
  end

  assign busy = busy_q;
endmodule

// File: rtl/event_status.sv
module event_status
  import bcm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t events,
  input  ev_vec_t clr_w1c,
  input  logic    mask_wr,
  input  ev_vec_t mask_wdata,
  input  logic    irq_en,
  output ev_vec_t raw_stat,
  output ev_vec_t masked_stat,
  output logic    irq
);
  ev_vec_t raw_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      // new event beats a simultaneous clear
      raw_q <= (raw_q & ~clr_w1c) | events;
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  assign raw_stat    = raw_q;
  assign masked_stat = raw_q & mask_q;
  assign irq         = irq_en & (|(raw_q & mask_q));
endmodule

// File: rtl/bus_cond_monitor.sv
module bus_cond_monitor
  import bcm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_in,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] filt_cycles,
  input  logic             irq_en,
  input  logic             mask_wr,
  input  logic [1:0]       mask_wdata,
  input  logic [1:0]       clr_w1c,
  output logic [1:0]       raw_stat,
  output logic [1:0]       masked_stat,
  output logic             bus_busy,
  output logic             irq
);
  logic [NUM_LINES-1:0] lines_raw, lines_filt;
  ev_vec_t              events;

  always_comb begin
    lines_raw         = '0;
    lines_raw[LN_SDA] = sda_in;
    lines_raw[LN_SCL] = scl_in;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_filter #(.CNT_W(CNT_W)) u_filt (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_in     (lines_raw[g]),
      .filt_cycles (filt_cycles),
      .line_out    (lines_filt[g])
    );
  end

  cond_detect u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .sda_f  (lines_filt[LN_SDA]),
    .scl_f  (lines_filt[LN_SCL]),
    .events (events),
    .busy   (bus_busy)
  );

  event_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .events      (events),
    .clr_w1c     (clr_w1c),
    .mask_wr     (mask_wr),
    .mask_wdata  (mask_wdata),
    .irq_en      (irq_en),
    .raw_stat    (raw_stat),
    .masked_stat (masked_stat),
    .irq         (irq)
  );
endmodule

// File: rtl/bus_cond_monitor_chk.sv
module bus_cond_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_en,
  input logic [1:0] clr_w1c,
  input logic [1:0] raw_stat,
  input logic [1:0] masked_stat,
  input logic       bus_busy,
  input logic       irq
);
  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> raw_stat[0]);

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> raw_stat[1]);

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && masked_stat != 2'b00));

  // R6
  start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[0] && !clr_w1c[0]) |=> raw_stat[0]);

  // R6
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[1] && !clr_w1c[1]) |=> raw_stat[1]);

  // R5
  masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_stat & ~raw_stat) == 2'b00);
endmodule

bind bus_cond_monitor bus_cond_monitor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_en      (irq_en),
  .clr_w1c     (clr_w1c),
  .raw_stat    (raw_stat),
  .masked_stat (masked_stat),
  .bus_busy    (bus_busy),
  .irq         (irq)
);

// File: tb/bus_cond_monitor_test.sv
module bus_cond_monitor_test;
  localparam int CNT_W = 4;
  localparam int HOLD  = 10;
  localparam int NVEC  = 12;
  // ops
  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_CLR = 3'd2,
                         OP_MASK = 3'd3, OP_IEN = 3'd4, OP_DATA = 3'd5;
  // {op, arg[1:0], exp_raw[1:0], exp_busy, exp_irq}
  localparam logic [8:0] VEC [NVEC] = '{
    {OP_START, 2'b00, 2'b01, 1'b1, 1'b0},  // R1 R3
    {OP_DATA,  2'b00, 2'b01, 1'b1, 1'b0},  // R3 no event with clock low
    {OP_CLR,   2'b01, 2'b00, 1'b1, 1'b0},  // R6
    {OP_START, 2'b00, 2'b01, 1'b1, 1'b0},  // R4 repeated
    {OP_MASK,  2'b01, 2'b01, 1'b1, 1'b0},  // R5 enable off
    {OP_IEN,   2'b01, 2'b01, 1'b1, 1'b1},  // R5
    {OP_STOP,  2'b00, 2'b11, 1'b0, 1'b1},  // R2 R3
    {OP_CLR,   2'b01, 2'b10, 1'b0, 1'b0},  // R6 R5
    {OP_MASK,  2'b10, 2'b10, 1'b0, 1'b1},  // R5
    {OP_CLR,   2'b00, 2'b10, 1'b0, 1'b1},  // R6 zero clear ignored
    {OP_CLR,   2'b10, 2'b00, 1'b0, 1'b0},  // R6
    {OP_IEN,   2'b00, 2'b00, 1'b0, 1'b0}   // R5
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sda_in = 1'b1, scl_in = 1'b1;
  logic [CNT_W-1:0] filt_cycles = 4'd3;
  logic             irq_en = 1'b0, mask_wr = 1'b0;
  logic [1:0]       mask_wdata = 2'b00, clr_w1c = 2'b00;
  logic [1:0]       raw_stat, masked_stat;
  logic             bus_busy, irq;
  logic [1:0]       tb_mask = 2'b00;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_cond_monitor #(.CNT_W(CNT_W)) uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lines(input logic d, input logic c);
    @(negedge clk);
    sda_in = d; scl_in = c;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic reg_pulse(input bit is_mask, input logic [1:0] v);
    @(negedge clk);
    if (is_mask) begin mask_wr = 1'b1; mask_wdata = v; tb_mask = v; end
    else clr_w1c = v;
    @(negedge clk);
    mask_wr = 1'b0; clr_w1c = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 raw in reset", {6'd0, raw_stat}, 8'd0);
    rst_n = 1'b1;
    repeat (HOLD) @(negedge clk);
    chk("R9 raw after reset", {6'd0, raw_stat}, 8'd0);
    chk("R9 busy after reset", {7'd0, bus_busy}, 8'd0);
    chk("R9 mask after reset", {6'd0, masked_stat}, 8'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] op;
      logic [1:0] arg;
      op = VEC[i][8:6]; arg = VEC[i][5:4];
      case (op)
        OP_START: begin lines(1, 0); lines(1, 1); lines(0, 1); lines(0, 0); end
        OP_STOP:  begin lines(0, 0); lines(0, 1); lines(1, 1); end
        OP_DATA:  begin lines(1, 0); lines(0, 0); lines(1, 0); lines(0, 0); end
        OP_CLR:   reg_pulse(0, arg);
        OP_MASK:  reg_pulse(1, arg);
        default:  begin @(negedge clk); irq_en = arg[0]; @(negedge clk); end
      endcase
      chk($sformatf("R1 R2 R6 raw vec %0d", i), {6'd0, raw_stat}, {6'd0, VEC[i][3:2]});
      chk($sformatf("R3 R4 busy vec %0d", i), {7'd0, bus_busy}, {7'd0, VEC[i][1]});
      chk($sformatf("R5 masked vec %0d", i), {6'd0, masked_stat}, {6'd0, VEC[i][3:2] & tb_mask});
      chk($sformatf("R5 irq vec %0d", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R8: two-clock glitch on data while clock high, length 3 -> dropped
    @(negedge clk); sda_in = 1'b0;
    @(negedge clk); @(negedge clk); sda_in = 1'b1;
    repeat (HOLD) @(negedge clk);
    chk("R8 short glitch dropped", {6'd0, raw_stat}, 8'd0);

    // R8: length 0 acts as 1, single-clock pulse gives start then stop
    filt_cycles = '0;
    @(negedge clk); sda_in = 1'b0;
    @(negedge clk); sda_in = 1'b1;
    repeat (HOLD) @(negedge clk);
    chk("R8 zero length passes pulse", {6'd0, raw_stat}, 8'b11);
    chk("R8 zero length busy free", {7'd0, bus_busy}, 8'd0);
    filt_cycles = 4'd3;
    repeat (HOLD) @(negedge clk);

    // R7: start bit already 1, clear lands with a new start
    @(negedge clk); sda_in = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); clr_w1c = 2'b01;
    @(negedge clk); clr_w1c = 2'b00;
    chk("R7 event wins over clear", {6'd0, raw_stat}, 8'b11);
    chk("R7 busy after start", {7'd0, bus_busy}, 8'd1);

    // R9: reset mid-operation
    reg_pulse(1, 2'b11);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; tb_mask = 2'b00;
    @(negedge clk);
    chk("R9 reset clears raw", {6'd0, raw_stat}, 8'd0);
    chk("R9 reset clears busy", {7'd0, bus_busy}, 8'd0);
    sda_in = 1'b1; scl_in = 1'b1;
    repeat (HOLD) @(negedge clk);
    chk("R9 reset clears mask", {6'd0, masked_stat}, 8'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule